// File: doc/BRIEF.md
# Hash Accelerator Register Front End

This block sits between a 32-bit register bus and a hash engine. Software programs a small configuration word and an interrupt mask, then runs each hash in three phases. A start command opens a message. Message writes, byte-wide or word-wide, are repacked into an ordered byte stream for the engine. A process command closes the message. While the engine works, the configuration cannot be changed. When the engine reports completion, the block latches the eight-word result and raises a sticky done flag. Software reads the result back through eight digest registers, which are laid out in reverse word order.

Every bus access completes in a single cycle. Read data is registered. The engine side has four parts: a one-cycle start pulse, a stream beat that carries one to four bytes, a one-cycle process pulse, and a done strobe with a 256-bit result bus. The hash algorithm itself lies outside this block.

Register map, as byte addresses: configuration 0x00, interrupt enable 0x04, interrupt status 0x08, command 0x0C, digest 0x10 to 0x2C, message port 0x30.

Top module: `hashctl_top`

## Requirements
- R1: After a synchronous reset the block is in the idle phase. The configuration, interrupt enable, done flag and all digest words are zero, and `irq` is low.
- R2: The configuration register is bit 0 keyed-mode enable, bit 1 hash enable, bit 2 input byte order, bit 3 result byte order, and it reads back at the same positions. A write changes it only in the idle phase. Writes made while consuming or processing are dropped.
- R3: A write to the interrupt enable register keeps only write data bits 2:0. Bits 31:3 read back as zero.
- R4: Interrupt status bit 0 is the done flag. Writing 1 to bit 0 clears it and writing 0 leaves it unchanged. If engine completion and a clearing write land on the same edge, the flag ends set.
- R5: Writing the command register with bit 0 set while idle enters the consuming phase. It also pulses `eng_start` high for exactly one cycle, on the cycle after the write, which tells the engine to empty its message buffer.
- R6: While consuming, a message-port write with `bus_byte`=1 produces one stream beat on the next cycle: `eng_valid`=1, `eng_nbytes`=1 and `eng_data[7:0]` equal to the write data bits 7:0, with the upper data bits zero.
- R7: While consuming, a message-port write with `bus_byte`=0 produces one beat carrying four bytes, where `eng_data[8k+7:8k]` is stream byte k. If configuration bit 2 is 1, stream byte k is write-data byte k, least significant first. If bit 2 is 0, the word is taken big-endian, so stream byte 0 is write-data bits 31:24.
- R8: Writing the command register with bit 1 set while consuming enters the processing phase and pulses `eng_process` for one cycle, on the cycle after the write.
- R9: An `eng_done` strobe while processing returns the block to idle on that edge. On the same edge it latches `eng_digest` and sets the done flag, even when all interrupt enables are zero.
- R10: Digest word i, which is `eng_digest[32i+31:32i]`, reads at address 0x2C − 4·i for i = 0 to 7. If configuration bit 3 is 1, each word reads back byte-reversed.
- R11: Certain writes are ignored: message writes outside the consuming phase, start commands outside idle, and process commands outside consuming. Neither a stream beat nor a pulse appears for them. If both command bits are written while idle, only the start takes effect. The command and message registers read as zero.
- R12: `irq` equals the done flag ANDed with interrupt enable bit 0.
- R13: Read data appears on `bus_rdata` on the cycle after `bus_rd` is sampled, and it holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_byte | input | 1 | Byte-wide access (used by message-port writes only) |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Done interrupt |
| eng_start | output | 1 | Pulse: begin a new message |
| eng_process | output | 1 | Pulse: message complete |
| eng_valid | output | 1 | Stream beat valid |
| eng_data | output | 32 | Stream bytes, byte 0 in bits 7:0 |
| eng_nbytes | output | 3 | Bytes in this beat (1 or 4) |
| eng_done | input | 1 | Engine completion strobe |
| eng_digest | input | 256 | Engine result, word i in bits 32i+31:32i |

## Verification
A behavioural model drives the same bus traffic through two complete hashes and compares against the design on every clock. The first hash mixes byte pushes with a word push under little-endian input order. The second uses big-endian word pushes. Because the engine stub's result depends on the order of the streamed bytes, a digest mismatch exposes any reordering or loss of bytes. The bench also sends writes and commands in the wrong phase, and the absence of any stream beat, pulse or configuration change tells ignored traffic apart from accepted traffic. Reading the digest with each value of the result-order bit, together with flag clears by 0 and by 1 under different enable masks, separates address reversal, byte swapping, write-one-to-clear and interrupt gating.

// File: rtl/hashctl_pkg.sv
// Shared types and constants for the hash front end.
// Assumes a 32-bit register bus; field positions are fixed by software.
package hashctl_pkg;
    localparam int BUS_W = 32;
    localparam int CFG_W = 4;
    localparam int IE_W  = 3;

    // configuration bit positions
    localparam int CFG_KEYED   = 0;
    localparam int CFG_HASH    = 1;
    localparam int CFG_IN_ORD  = 2;
    localparam int CFG_OUT_ORD = 3;

    // command and status bit positions
    localparam int CMD_OPEN  = 0;
    localparam int CMD_CLOSE = 1;
    localparam int STS_DONE  = 0;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CONS = 2'd1,
        PH_PROC = 2'd2
    } hc_phase_e;

    // reverse the byte order of a bus word
    function automatic logic [BUS_W-1:0] swap_bytes(input logic [BUS_W-1:0] w);
        logic [BUS_W-1:0] r;
        for (int k = 0; k < BUS_W/8; k++) begin
            r[8*k +: 8] = w[BUS_W-8-8*k +: 8];
        end
        return r;
    endfunction
endpackage

// File: rtl/hashctl_fsm.sv
// Three-phase lifecycle: idle -> consuming -> processing -> idle.
// Assumes command requests are raw decoded bits; validity is decided here.
module hashctl_fsm
    import hashctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      open_req,
    input  logic      close_req,
    input  logic      eng_done,
    output hc_phase_e phase,
    output logic      open_go,
    output logic      close_go,
    output logic      finish_go
);
    // qualify each request against the current phase
    always_comb begin
        open_go   = open_req  && (phase == PH_IDLE);
        close_go  = close_req && (phase == PH_CONS);
        finish_go = eng_done  && (phase == PH_PROC);
    end

    // phase register
    always_ff @(posedge clk) begin
        if (!rst_n)         phase <= PH_IDLE;
        else if (open_go)   phase <= PH_CONS;
        else if (close_go)  phase <= PH_PROC;
        else if (finish_go) phase <= PH_IDLE;
    end

    a_r5_open_enters_consuming: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && open_req) |=> (phase == PH_CONS));
    a_r8_close_enters_processing: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CONS && close_req) |=> (phase == PH_PROC));
    a_r9_done_returns_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_PROC && eng_done) |=> (phase == PH_IDLE));
    a_r11_open_ignored_in_processing: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_PROC && open_req && !eng_done) |=> (phase == PH_PROC));
    a_r1_legal_phase: assert property (@(posedge clk) disable iff (!rst_n)
        phase != hc_phase_e'(2'd3));
endmodule

// File: rtl/hashctl_pack.sv
// Repacks an accepted message write into one stream beat of 1 or 4 bytes.
// Assumes the caller only pushes while consuming; beat is registered.
module hashctl_pack
    import hashctl_pkg::*;
#(
    parameter int W = BUS_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         is_byte,
    input  logic         lsb_first,
    input  logic [W-1:0] wdata,
    output logic         beat_valid,
    output logic [W-1:0] beat_data,
    output logic [2:0]   beat_nbytes
);
    localparam int NB = W / 8;

    logic [W-1:0] word_ordered;

    // choose the byte order of a full-word push
    always_comb begin
        word_ordered = lsb_first ? wdata : swap_bytes(wdata);
    end

    // register one beat per accepted push
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_valid  <= 1'b0;
            beat_data   <= '0;
            beat_nbytes <= '0;
        end else begin
            beat_valid <= push;
            if (push) begin
                beat_data   <= is_byte ? {{(W-8){1'b0}}, wdata[7:0]} : word_ordered;
                beat_nbytes <= is_byte ? 3'd1 : 3'(NB);
            end
        end
    end

    a_r6_byte_push_one_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (push && is_byte) |=> (beat_valid && beat_nbytes == 3'd1));
    a_r7_word_push_four_bytes: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !is_byte) |=> (beat_valid && beat_nbytes == 3'(NB)));
endmodule

// File: rtl/hashctl_digest.sv
// Holds the engine result and returns one selected word, optionally byte-swapped.
// Assumes WORDS is a power of two so every select value is in range.
module hashctl_digest
    import hashctl_pkg::*;
#(
    parameter int WORDS = 8,
    parameter int W     = BUS_W,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               capture,
    input  logic [WORDS*W-1:0] eng_digest,
    input  logic [IDX_W-1:0]   sel,
    input  logic               swap,
    output logic [W-1:0]       rd_word
);
    logic [W-1:0] words [WORDS];

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        // latch word i on completion
        always_ff @(posedge clk) begin
            if (!rst_n)       words[i] <= '0;
            else if (capture) words[i] <= eng_digest[W*i +: W];
        end
    end

    // readout mux with optional byte reversal
    always_comb begin
        rd_word = swap ? swap_bytes(words[sel]) : words[sel];
    end

    a_r9_capture_low_word: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (words[0] == $past(eng_digest[W-1:0])));
    a_r9_hold_without_capture: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(words[WORDS-1]));
endmodule

// File: rtl/hashctl_top.sv
// Register front end of a hash accelerator: decode, control registers,
// lifecycle, message repacking and digest readout.
// Assumes single-cycle bus accesses, never a read and a write together.
module hashctl_top
    import hashctl_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DIG_WORDS = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_rd,
    input  logic                     bus_wr,
    input  logic                     bus_byte,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [BUS_W-1:0]         bus_wdata,
    output logic [BUS_W-1:0]         bus_rdata,
    output logic                     irq,
    output logic                     eng_start,
    output logic                     eng_process,
    output logic                     eng_valid,
    output logic [BUS_W-1:0]         eng_data,
    output logic [2:0]               eng_nbytes,
    input  logic                     eng_done,
    input  logic [DIG_WORDS*BUS_W-1:0] eng_digest
);
    localparam int IDX_W  = $clog2(DIG_WORDS);
    localparam int OFF_CFG = 'h00;
    localparam int OFF_IE  = 'h04;
    localparam int OFF_STS = 'h08;
    localparam int OFF_CMD = 'h0C;
    localparam int OFF_DLO = 'h10;
    localparam int OFF_DHI = OFF_DLO + 4 * (DIG_WORDS - 1);
    localparam int OFF_MSG = OFF_DHI + 4;

    hc_phase_e        phase;
    logic             open_go, close_go, finish_go;
    logic [CFG_W-1:0] cfg_q;
    logic [IE_W-1:0]  ie_q;
    logic             done_q;
    logic             wr_cfg, wr_ie, wr_sts, wr_cmd, wr_msg;
    logic             dig_hit;
    logic [IDX_W-1:0] dig_sel;
    logic [BUS_W-1:0] dig_word;
    logic [BUS_W-1:0] rd_mux;

    // write decode
    always_comb begin
        wr_cfg = bus_wr && (bus_addr == ADDR_W'(OFF_CFG));
        wr_ie  = bus_wr && (bus_addr == ADDR_W'(OFF_IE));
        wr_sts = bus_wr && (bus_addr == ADDR_W'(OFF_STS));
        wr_cmd = bus_wr && (bus_addr == ADDR_W'(OFF_CMD));
        wr_msg = bus_wr && (bus_addr == ADDR_W'(OFF_MSG));
    end

    // digest address to word index, highest address holds word 0
    always_comb begin
        dig_hit = 1'b0;
        dig_sel = '0;
        for (int i = 0; i < DIG_WORDS; i++) begin
            if (bus_addr == ADDR_W'(OFF_DHI - 4 * i)) begin
                dig_hit = 1'b1;
                dig_sel = IDX_W'(i);
            end
        end
    end

    hashctl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .open_req  (wr_cmd && bus_wdata[CMD_OPEN]),
        .close_req (wr_cmd && bus_wdata[CMD_CLOSE]),
        .eng_done  (eng_done),
        .phase     (phase),
        .open_go   (open_go),
        .close_go  (close_go),
        .finish_go (finish_go)
    );

    hashctl_pack #(.W(BUS_W)) u_pack (
        .clk         (clk),
        .rst_n       (rst_n),
        .push        (wr_msg && (phase == PH_CONS)),
        .is_byte     (bus_byte),
        .lsb_first   (cfg_q[CFG_IN_ORD]),
        .wdata       (bus_wdata),
        .beat_valid  (eng_valid),
        .beat_data   (eng_data),
        .beat_nbytes (eng_nbytes)
    );

    hashctl_digest #(.WORDS(DIG_WORDS), .W(BUS_W)) u_digest (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (finish_go),
        .eng_digest (eng_digest),
        .sel        (dig_sel),
        .swap       (cfg_q[CFG_OUT_ORD]),
        .rd_word    (dig_word)
    );

    // configuration, locked outside idle
    always_ff @(posedge clk) begin
        if (!rst_n)                           cfg_q <= '0;
        else if (wr_cfg && phase == PH_IDLE)  cfg_q <= bus_wdata[CFG_W-1:0];
    end

    // interrupt enable keeps the low bits only
    always_ff @(posedge clk) begin
        if (!rst_n)     ie_q <= '0;
        else if (wr_ie) ie_q <= bus_wdata[IE_W-1:0];
    end

    // sticky done flag: engine completion sets, write-one clears
    always_ff @(posedge clk) begin
        if (!rst_n)                               done_q <= 1'b0;
        else if (finish_go)                       done_q <= 1'b1;
        else if (wr_sts && bus_wdata[STS_DONE])   done_q <= 1'b0;
    end

    // one-cycle engine command pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_start   <= 1'b0;
            eng_process <= 1'b0;
        end else begin
            eng_start   <= open_go;
            eng_process <= close_go;
        end
    end

    // read data selection
    always_comb begin
        rd_mux = '0;
        if (bus_addr == ADDR_W'(OFF_CFG))      rd_mux = BUS_W'(cfg_q);
        else if (bus_addr == ADDR_W'(OFF_IE))  rd_mux = BUS_W'(ie_q);
        else if (bus_addr == ADDR_W'(OFF_STS)) rd_mux = BUS_W'(done_q);
        else if (dig_hit)                      rd_mux = dig_word;
    end

    // registered read port
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    assign irq = done_q & ie_q[0];

    a_r2_cfg_locked_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE) |=> $stable(cfg_q));
    a_r9_done_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        finish_go |=> done_q);
    a_r4_write_one_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sts && bus_wdata[STS_DONE] && !finish_go) |=> !done_q);
    a_r4_write_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sts && !bus_wdata[STS_DONE] && done_q) |=> done_q);
    a_r11_no_beat_outside_consuming: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_CONS) |=> !eng_valid);
    a_r13_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/hashctl_top_tb.sv
`timescale 1ns/1ps
module hashctl_top_tb;
    localparam int CLK_P = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_rd = 1'b0, bus_wr = 1'b0, bus_byte = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         irq, eng_start, eng_process, eng_valid;
    logic [31:0]  eng_data;
    logic [2:0]   eng_nbytes;
    logic         eng_done = 1'b0;
    logic [255:0] eng_digest = '0;

    always #(CLK_P/2) clk = ~clk;

    hashctl_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_byte(bus_byte), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq), .eng_start(eng_start),
        .eng_process(eng_process), .eng_valid(eng_valid), .eng_data(eng_data),
        .eng_nbytes(eng_nbytes), .eng_done(eng_done), .eng_digest(eng_digest)
    );

    int    n_cmp = 0, n_bad = 0;
    string cur_tag = "R1";
    bit    started = 0;

    // order-sensitive stand-in result
    function automatic logic [31:0] stub_word(input logic [7:0] q[$], input int i);
        logic [31:0] h = 32'h811C9DC5;
        foreach (q[k]) h = (h ^ {24'd0, q[k]}) * 32'd16777619;
        return h + 32'(i) * 32'h9E3779B9;
    endfunction

    function automatic logic [31:0] rev(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    // ---------------- reference model ----------------
    int          m_phase;
    logic [3:0]  m_cfg;
    logic [2:0]  m_ie;
    logic        m_done;
    logic [31:0] m_dig [8];
    logic [7:0]  m_q [$];
    logic        e_valid, e_start, e_proc, e_rchk;
    logic [31:0] e_data, e_rdata;
    logic [2:0]  e_nb;

    function automatic logic [31:0] model_read(input logic [7:0] a);
        logic [31:0] r = '0;
        if (a == 8'h00) r = {28'd0, m_cfg};
        else if (a == 8'h04) r = {29'd0, m_ie};
        else if (a == 8'h08) r = {31'd0, m_done};
        for (int i = 0; i < 8; i++)
            if (a == 8'(8'h2C - 4 * i)) r = m_cfg[3] ? rev(m_dig[i]) : m_dig[i];
        return r;
    endfunction

    always @(posedge clk) begin
        int os;
        started = 1;
        e_valid = 0; e_start = 0; e_proc = 0; e_rchk = 0;
        if (!rst_n) begin
            m_phase = 0; m_cfg = 0; m_ie = 0; m_done = 0; e_rdata = 0;
            for (int i = 0; i < 8; i++) m_dig[i] = 0;
        end else begin
            os = m_phase;
            if (bus_rd) begin e_rdata = model_read(bus_addr); e_rchk = 1; end
            if (bus_wr) begin
                case (bus_addr)
                    8'h00: if (os == 0) m_cfg = bus_wdata[3:0];
                    8'h04: m_ie = bus_wdata[2:0];
                    8'h08: if (bus_wdata[0]) m_done = 0;
                    8'h0C: begin
                        if (os == 0 && bus_wdata[0]) begin m_phase = 1; m_q.delete(); e_start = 1; end
                        else if (os == 1 && bus_wdata[1]) begin m_phase = 2; e_proc = 1; end
                    end
                    8'h30: if (os == 1) begin
                        e_valid = 1;
                        if (bus_byte) begin
                            e_nb = 1; e_data = {24'd0, bus_wdata[7:0]}; m_q.push_back(bus_wdata[7:0]);
                        end else begin
                            e_nb = 4;
                            e_data = m_cfg[2] ? bus_wdata : rev(bus_wdata);
                            for (int k = 0; k < 4; k++) m_q.push_back(e_data[8*k +: 8]);
                        end
                    end
                    default: ;
                endcase
            end
            if (eng_done && os == 2) begin
                m_phase = 0; m_done = 1;
                for (int i = 0; i < 8; i++) m_dig[i] = stub_word(m_q, i);
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (started) begin
            chk("R12 irq", {31'd0, irq}, {31'd0, m_done & m_ie[0]});
            chk("R5 eng_start", {31'd0, eng_start}, {31'd0, e_start});
            chk("R8 eng_process", {31'd0, eng_process}, {31'd0, e_proc});
            chk({cur_tag, " eng_valid"}, {31'd0, eng_valid}, {31'd0, e_valid});
            if (e_valid) begin
                chk({cur_tag, " eng_data"}, eng_data, e_data);
                chk({cur_tag, " eng_nbytes"}, {29'd0, eng_nbytes}, {29'd0, e_nb});
            end
            if (e_rchk) chk({cur_tag, " R13 rdata"}, bus_rdata, e_rdata);
        end
    end

    // ---------------- engine stub ----------------
    logic [7:0] s_q [$];
    int         s_delay = 0;
    always @(negedge clk) begin
        eng_done = 1'b0;
        if (s_delay > 0) begin
            s_delay--;
            if (s_delay == 0) begin
                eng_done = 1'b1;
                for (int i = 0; i < 8; i++) eng_digest[32*i +: 32] = stub_word(s_q, i);
            end
        end
        if (eng_start) s_q.delete();
        if (eng_valid) for (int k = 0; k < int'(eng_nbytes); k++) s_q.push_back(eng_data[8*k +: 8]);
        if (eng_process) s_delay = 6;
    end

    // ---------------- stimulus ----------------
    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic b = 1'b0);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d; bus_byte = b;
        @(negedge clk);
        bus_wr = 0; bus_byte = 0;
    endtask

    task automatic rd(input logic [7:0] a);
        @(negedge clk);
        bus_rd = 1; bus_addr = a;
        @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic wait_idle();
        for (int t = 0; t < 40 && m_phase != 0; t++) @(negedge clk);
    endtask

    task automatic read_digest();
        for (int i = 0; i < 8; i++) rd(8'(8'h2C - 4 * i));
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_P * 100000);
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        cur_tag = "R1";
        rd(8'h00); rd(8'h04); rd(8'h08); rd(8'h2C); rd(8'h10);
        cur_tag = "R11";
        rd(8'h0C); rd(8'h30);
        wr(8'h30, 32'hDEAD_BEEF);            // message write while idle
        wr(8'h0C, 32'h2);                    // close while idle
        cur_tag = "R2";
        wr(8'h00, 32'hFFFF_FFFF); rd(8'h00);
        wr(8'h00, 32'h5); rd(8'h00);
        cur_tag = "R3";
        wr(8'h04, 32'hFFFF_FFF8); rd(8'h04);
        wr(8'h04, 32'hFFFF_FFFF); rd(8'h04);
        cur_tag = "R5";
        wr(8'h00, 32'h6);
        wr(8'h0C, 32'h1);
        cur_tag = "R2";
        wr(8'h00, 32'h0); rd(8'h00);         // locked while consuming
        cur_tag = "R6";
        wr(8'h30, 32'hFFFF_FFA1, 1'b1);
        wr(8'h30, 32'h0000_02B2, 1'b1);
        cur_tag = "R7";
        wr(8'h30, 32'h4433_2211);
        cur_tag = "R11";
        wr(8'h0C, 32'h1);                    // open while consuming
        cur_tag = "R8";
        wr(8'h0C, 32'h2);
        cur_tag = "R11";
        wr(8'h30, 32'h5555_5555);            // message write while processing
        cur_tag = "R9";
        wait_idle();
        rd(8'h08);
        cur_tag = "R12";
        wr(8'h04, 32'h0);
        wr(8'h04, 32'h1);
        cur_tag = "R10";
        read_digest();
        wr(8'h00, 32'hE);
        read_digest();
        cur_tag = "R4";
        wr(8'h08, 32'hFFFF_FFFE); rd(8'h08);
        wr(8'h08, 32'h1); rd(8'h08);
        cur_tag = "R7";
        wr(8'h04, 32'h0);
        wr(8'h00, 32'h2);                    // big-endian input, no result swap
        wr(8'h0C, 32'h3);                    // both bits while idle: open only
        wr(8'h30, 32'hA1B2_C3D4);
        wr(8'h30, 32'h0102_0304);
        wr(8'h30, 32'h0000_0077, 1'b1);
        wr(8'h0C, 32'h2);
        wait_idle();
        cur_tag = "R9";
        rd(8'h08);                           // flag set with enables off
        cur_tag = "R10";
        read_digest();
        cur_tag = "R1";
        @(negedge clk); rst_n = 0;
        repeat (2) @(negedge clk); rst_n = 1;
        rd(8'h08); rd(8'h2C); rd(8'h00);
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule